// File: doc/BRIEF.md
# Dual-clock FIFO controller with run-time flag thresholds

This block turns a simple dual-clock RAM, kept outside the block, into a first-in first-out queue. It generates the RAM write and read addresses itself, keeps a pointer for each side, and works out the current fill level on each side from its own pointer and a synchronised copy of the other one. From that fill level it produces four status flags. `full` and `afull` belong to the write clock. `empty` and `aempty` belong to the read clock. The almost-full and almost-empty limits come from input pins and can be changed at run time.

The two pointers are one bit wider than the RAM address. Each crosses to the other clock in Gray code through a two-stage synchroniser. A flag sets on the local clock edge of the access that causes it. It clears only after the access on the far side has come through the synchroniser. Two stop inputs choose what happens at the boundaries. With a stop input high, an access that would overflow or underflow is dropped. With it low, the access goes ahead and the pointer wraps.

Setting `fifo_mode` low bypasses the controller. The user addresses and enables then go straight to the RAM, and both pointers keep their values. There is no data path here: `wr_en` and `rd_en` are plain strobes. The back-pressure rule is that a write issued while `full` is set with `stop_on_full` high is lost. Likewise, a read issued while `empty` is set with `stop_on_empty` high is lost. The user is expected to watch the flags.

Top module: `dcfifo_ctrl`

## Requirements
- R1: While `rst_n` is low and after it is released, both pointers are zero, `empty` and `aempty` are 1, and `full` and `afull` are 0 (for thresholds with `afull_lvl` > 0).
- R2: In FIFO mode, each accepted write drives `ram_we` high with `ram_waddr` equal to the number of earlier accepted writes modulo DEPTH. Reads do the same with `ram_re` and `ram_raddr`, so data comes out in the order it went in.
- R3: `full` is 1 from the write clock edge that takes the write-side fill level to DEPTH.
- R4: With `stop_on_full` = 1, a write while `full` = 1 is dropped: `ram_we` stays 0 and the write address does not move.
- R5: With `stop_on_full` = 0, a write while `full` = 1 is accepted: `ram_we` = 1 and the address wraps to the oldest slot.
- R6: `empty` is 1 from the read clock edge that drains the last entry. With `stop_on_empty` = 1, a read while `empty` = 1 is dropped (`ram_re` = 0).
- R7: With `stop_on_empty` = 0, a read while `empty` = 1 is accepted (`ram_re` = 1) and the read address moves on.
- R8: `afull` is 1 exactly when the write-side fill level is at least `afull_lvl`. It is updated on every write clock edge.
- R9: `aempty` is 1 exactly when the read-side fill level is at most `aempty_lvl`. It is updated on every read clock edge.
- R10: `empty` stays 1 for at least one read clock edge after a write into an empty queue, and clears within a few read clock edges. `full` behaves the same way on the write clock after a read from a full queue.
- R11: With `fifo_mode` = 0, `ram_waddr`/`ram_we` follow `usr_waddr`/`wr_en`, and `ram_raddr`/`ram_re` follow `usr_raddr`/`rd_en`. The pointers and flags do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| fifo_mode | input | 1 | 1: internal addressing; 0: user addresses pass through |
| wr_en | input | 1 | Write strobe (write clock) |
| rd_en | input | 1 | Read strobe (read clock) |
| usr_waddr | input | AW | User write address in bypass mode |
| usr_raddr | input | AW | User read address in bypass mode |
| afull_lvl | input | AW+1 | Almost-full limit |
| aempty_lvl | input | AW+1 | Almost-empty limit |
| stop_on_full | input | 1 | Drop writes while full |
| stop_on_empty | input | 1 | Drop reads while empty |
| full | output | 1 | Queue full (write clock) |
| afull | output | 1 | Fill level at or above `afull_lvl` (write clock) |
| empty | output | 1 | Queue empty (read clock) |
| aempty | output | 1 | Fill level at or below `aempty_lvl` (read clock) |
| ram_waddr | output | AW | RAM write address |
| ram_we | output | 1 | RAM write enable |
| ram_raddr | output | AW | RAM read address |
| ram_re | output | 1 | RAM read enable |

## Verification
The bench runs the queue in four ways:
- A full fill followed by a full drain shows that every flag crosses its threshold on the right access, counting edge by edge.
- Accesses at the two boundaries, once with each stop setting, tell a dropped access from a wrapped one, both at the enables and at the addresses.
- A concurrent stream with uneven gaps on two unrelated clocks checks ordering through the Gray crossing against a scoreboard.
- A bypass pass followed by a resumed queue shows that user addressing leaves the pointers alone. Threshold changes while the queue sits at a fixed level show that the almost flags follow the inputs and not just the accesses.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;
  // Gray code helpers on a 32-bit carrier; callers cast to their width.
  function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/dcfifo_sync.sv
module dcfifo_sync #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/dcfifo_wside.sv
module dcfifo_wside
  import dcfifo_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        stop,
  input  logic [AW:0] far_gray,
  input  logic [AW:0] lvl,
  output logic [AW:0] own_gray,
  output logic [AW-1:0] addr,
  output logic        acc,
  output logic        full,
  output logic        afull
);
  logic [AW:0] ptr, ptr_nx, far_bin, occ_nx;

  assign far_bin = (AW+1)'(gray_to_bin(32'(far_gray)));
  assign acc     = req && !(stop && full);
  assign ptr_nx  = ptr + (AW+1)'(acc);
  assign occ_nx  = ptr_nx - far_bin;
  assign addr    = ptr[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr      <= '0;
      own_gray <= '0;
      full     <= 1'b0;
      afull    <= 1'b0;
    end else begin
      ptr      <= ptr_nx;
      own_gray <= (AW+1)'(bin_to_gray(32'(ptr_nx)));
      full     <= occ_nx[AW];
      afull    <= (occ_nx >= lvl);
    end
  end
endmodule

// File: rtl/dcfifo_rside.sv
module dcfifo_rside
  import dcfifo_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        stop,
  input  logic [AW:0] far_gray,
  input  logic [AW:0] lvl,
  output logic [AW:0] own_gray,
  output logic [AW-1:0] addr,
  output logic        acc,
  output logic        empty,
  output logic        aempty
);
  logic [AW:0] ptr, ptr_nx, far_bin, occ_nx;

  assign far_bin = (AW+1)'(gray_to_bin(32'(far_gray)));
  assign acc     = req && !(stop && empty);
  assign ptr_nx  = ptr + (AW+1)'(acc);
  assign occ_nx  = far_bin - ptr_nx;
  assign addr    = ptr[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr      <= '0;
      own_gray <= '0;
      empty    <= 1'b1;
      aempty   <= 1'b1;
    end else begin
      ptr      <= ptr_nx;
      own_gray <= (AW+1)'(bin_to_gray(32'(ptr_nx)));
      empty    <= (occ_nx == '0);
      aempty   <= (occ_nx <= lvl);
    end
  end
endmodule

// File: rtl/dcfifo_ctrl.sv
module dcfifo_ctrl #(
  parameter int AW = 12
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          fifo_mode,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] usr_waddr,
  input  logic [AW-1:0] usr_raddr,
  input  logic [AW:0]   afull_lvl,
  input  logic [AW:0]   aempty_lvl,
  input  logic          stop_on_full,
  input  logic          stop_on_empty,
  output logic          full,
  output logic          afull,
  output logic          empty,
  output logic          aempty,
  output logic [AW-1:0] ram_waddr,
  output logic          ram_we,
  output logic [AW-1:0] ram_raddr,
  output logic          ram_re
);
  localparam int PW = AW + 1;

  logic [PW-1:0] wgray, rgray, wgray_in_r, rgray_in_w;
  logic [AW-1:0] waddr_i, raddr_i;
  logic          wacc, racc;

  dcfifo_wside #(.AW(AW)) u_wside (
    .clk(wclk), .rst_n(rst_n), .req(wr_en && fifo_mode), .stop(stop_on_full),
    .far_gray(rgray_in_w), .lvl(afull_lvl), .own_gray(wgray), .addr(waddr_i),
    .acc(wacc), .full(full), .afull(afull)
  );

  dcfifo_rside #(.AW(AW)) u_rside (
    .clk(rclk), .rst_n(rst_n), .req(rd_en && fifo_mode), .stop(stop_on_empty),
    .far_gray(wgray_in_r), .lvl(aempty_lvl), .own_gray(rgray), .addr(raddr_i),
    .acc(racc), .empty(empty), .aempty(aempty)
  );

  dcfifo_sync #(.W(PW)) u_w2r (.clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_in_r));
  dcfifo_sync #(.W(PW)) u_r2w (.clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_in_w));

  assign ram_we    = fifo_mode ? wacc    : wr_en;
  assign ram_waddr = fifo_mode ? waddr_i : usr_waddr;
  assign ram_re    = fifo_mode ? racc    : rd_en;
  assign ram_raddr = fifo_mode ? raddr_i : usr_raddr;
endmodule

// File: rtl/dcfifo_chk.sv
module dcfifo_chk #(
  parameter int AW = 12
) (
  input logic          wclk,
  input logic          rclk,
  input logic          rst_n,
  input logic          fifo_mode,
  input logic          stop_on_full,
  input logic          stop_on_empty,
  input logic [AW:0]   afull_lvl,
  input logic          full,
  input logic          afull,
  input logic          empty,
  input logic          aempty,
  input logic [AW-1:0] ram_waddr,
  input logic          ram_we,
  input logic [AW-1:0] ram_raddr,
  input logic          ram_re
);
  localparam int DEPTH = 1 << AW;

  // R4: a blocked write leaves the write address where it was
  a_r4_hold_waddr: assert property (@(posedge wclk) disable iff (!rst_n)
    (fifo_mode && stop_on_full && full) |=> (!fifo_mode || $stable(ram_waddr)));

  // R6: a blocked read leaves the read address where it was
  a_r6_hold_raddr: assert property (@(posedge rclk) disable iff (!rst_n)
    (fifo_mode && stop_on_empty && empty) |=> (!fifo_mode || $stable(ram_raddr)));

  // R2: write address steps by one per accepted write
  a_r2_waddr_step: assert property (@(posedge wclk) disable iff (!rst_n)
    (fifo_mode && ram_we) |=> (!fifo_mode || ram_waddr == AW'($past(ram_waddr) + 1'b1)));

  // R2: read address steps by one per accepted read
  a_r2_raddr_step: assert property (@(posedge rclk) disable iff (!rst_n)
    (fifo_mode && ram_re) |=> (!fifo_mode || ram_raddr == AW'($past(ram_raddr) + 1'b1)));

  // R8: a full queue is at or above any reachable almost-full limit
  a_r8_full_afull: assert property (@(posedge wclk) disable iff (!rst_n)
    (full && ({1'b0, afull_lvl} <= (AW+2)'(DEPTH)) && $stable(afull_lvl)) |-> afull);

  // R9: an empty queue is always almost empty
  a_r9_empty_aempty: assert property (@(posedge rclk) disable iff (!rst_n)
    empty |-> aempty);
endmodule

bind dcfifo_ctrl dcfifo_chk #(.AW(AW)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .fifo_mode(fifo_mode),
  .stop_on_full(stop_on_full), .stop_on_empty(stop_on_empty), .afull_lvl(afull_lvl),
  .full(full), .afull(afull), .empty(empty), .aempty(aempty),
  .ram_waddr(ram_waddr), .ram_we(ram_we), .ram_raddr(ram_raddr), .ram_re(ram_re)
);

// File: tb/test_dcfifo_ctrl.sv
module test_dcfifo_ctrl;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic wclk = 0, rclk = 0, rst_n = 0;
  logic fifo_mode = 1, wr_en = 0, rd_en = 0;
  logic [AW-1:0] usr_waddr = '0, usr_raddr = '0;
  logic [AW:0] afull_lvl = 12, aempty_lvl = 3;
  logic stop_on_full = 1, stop_on_empty = 1;
  logic full, afull, empty, aempty, ram_we, ram_re;
  logic [AW-1:0] ram_waddr, ram_raddr;

  logic [15:0] mem [0:DEPTH-1];
  logic [15:0] sb[$];
  int nchk = 0, nerr = 0;
  logic [15:0] seed = 16'h1000;

  always #5 wclk = ~wclk;
  always #7 rclk = ~rclk;

  dcfifo_ctrl #(.AW(AW)) i_dcfifo_ctrl (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .fifo_mode(fifo_mode),
    .wr_en(wr_en), .rd_en(rd_en), .usr_waddr(usr_waddr), .usr_raddr(usr_raddr),
    .afull_lvl(afull_lvl), .aempty_lvl(aempty_lvl),
    .stop_on_full(stop_on_full), .stop_on_empty(stop_on_empty),
    .full(full), .afull(afull), .empty(empty), .aempty(aempty),
    .ram_waddr(ram_waddr), .ram_we(ram_we), .ram_raddr(ram_raddr), .ram_re(ram_re)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  endtask

  // Driver: one write strobe; queues the item when the RAM write fires.
  task automatic push_w(output bit acc, output int addr);
    @(negedge wclk);
    wr_en = 1;
    #1;
    acc  = ram_we;
    addr = int'(ram_waddr);
    if (acc) begin
      mem[ram_waddr] = seed;
      sb.push_back(seed);
      seed++;
    end
    @(posedge wclk);
    #1 wr_en = 0;
  endtask

  // Monitor: one read strobe; pops the scoreboard and compares.
  task automatic pop_r(input bit cmp, output bit acc, output int addr);
    logic [15:0] exp_d;
    @(negedge rclk);
    rd_en = 1;
    #1;
    acc  = ram_re;
    addr = int'(ram_raddr);
    if (acc && cmp) begin
      if (sb.size() == 0) check(0, "R2 read with nothing queued", 1, 0);
      else begin
        exp_d = sb.pop_front();
        check(mem[ram_raddr] == exp_d, "R2 data order", int'(mem[ram_raddr]), int'(exp_d));
      end
    end
    @(posedge rclk);
    #1 rd_en = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    wr_en = 0;
    rd_en = 0;
    repeat (3) @(negedge wclk);
    repeat (3) @(negedge rclk);
    sb.delete();
    rst_n = 1;
    repeat (2) @(negedge wclk);
  endtask

  initial begin
    #1_000_000;
    nerr++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
  end

  initial begin
    bit a;
    int ad;
    do_reset();
    // R1 reset state
    check(empty == 1 && aempty == 1, "R1 empty/aempty", int'({empty, aempty}), 3);
    check(full == 0 && afull == 0, "R1 full/afull", int'({full, afull}), 0);

    // R10 empty latency
    push_w(a, ad);
    check(ad == 0 && a, "R2 first waddr", ad, 0);
    @(negedge rclk);
    check(empty == 1, "R10 empty held", int'(empty), 1);
    repeat (4) @(negedge rclk);
    check(empty == 0, "R10 empty clears", int'(empty), 0);
    check(aempty == 1, "R9 aempty at 1", int'(aempty), 1);

    // R3/R8 fill
    for (int n = 2; n <= DEPTH; n++) begin
      push_w(a, ad);
      check(a && ad == n - 1, "R2 waddr sequence", ad, n - 1);
      check(afull == (n >= 12), "R8 afull level", int'(afull), int'(n >= 12));
      check(full == (n == DEPTH), "R3 full level", int'(full), int'(n == DEPTH));
    end

    // R4 write while full dropped
    push_w(a, ad);
    check(a == 0, "R4 write dropped", int'(a), 0);
    check(full == 1, "R4 still full", int'(full), 1);

    // R10 full latency
    pop_r(1, a, ad);
    @(negedge wclk);
    check(full == 1, "R10 full held", int'(full), 1);
    repeat (4) @(negedge wclk);
    check(full == 0, "R10 full clears", int'(full), 0);
    check(afull == 1, "R8 afull at 15", int'(afull), 1);

    // R6/R9 drain
    for (int m = DEPTH - 2; m >= 0; m--) begin
      pop_r(1, a, ad);
      check(a == 1, "R2 read accepted", int'(a), 1);
      check(aempty == (m <= 3), "R9 aempty level", int'(aempty), int'(m <= 3));
      check(empty == (m == 0), "R6 empty level", int'(empty), int'(m == 0));
    end
    pop_r(1, a, ad);
    check(a == 0, "R6 read dropped at empty", int'(a), 0);

    // R7 read at empty allowed
    stop_on_empty = 0;
    pop_r(0, a, ad);
    check(a == 1 && ad == 0, "R7 read wraps", ad, 0);
    stop_on_empty = 1;
    do_reset();

    // R5 write at full allowed
    stop_on_full = 0;
    for (int n = 0; n < DEPTH; n++) push_w(a, ad);
    check(full == 1, "R5 full before", int'(full), 1);
    push_w(a, ad);
    check(a == 1 && ad == 0, "R5 write wraps", ad, 0);
    stop_on_full = 1;
    do_reset();

    // R11 bypass
    for (int n = 0; n < 3; n++) push_w(a, ad);
    @(negedge wclk);
    fifo_mode = 0;
    usr_waddr = 5;
    usr_raddr = 9;
    wr_en = 1;
    rd_en = 1;
    #1;
    check(ram_we == 1 && ram_waddr == 5, "R11 write passthrough", int'(ram_waddr), 5);
    check(ram_re == 1 && ram_raddr == 9, "R11 read passthrough", int'(ram_raddr), 9);
    repeat (4) @(negedge rclk);
    wr_en = 0;
    rd_en = 0;
    fifo_mode = 1;
    repeat (2) @(negedge wclk);
    check(full == 0 && afull == 0, "R11 write flags", int'({full, afull}), 0);
    push_w(a, ad);
    check(ad == 3, "R11 write pointer kept", ad, 3);
    pop_r(1, a, ad);
    check(ad == 0, "R11 read pointer kept", ad, 0);
    do_reset();

    // R2 concurrent stream
    fork
      begin
        int got = 0;
        int k = 0;
        while (got < 40) begin
          push_w(a, ad);
          if (a) got++;
          k++;
          repeat (k % 3) @(negedge wclk);
        end
      end
      begin
        bit ra;
        int rad;
        int got = 0;
        int k = 0;
        while (got < 40) begin
          pop_r(1, ra, rad);
          if (ra) got++;
          k++;
          repeat (k % 4) @(negedge rclk);
        end
      end
    join
    check(sb.size() == 0, "R2 stream drained", sb.size(), 0);

    // R8/R9 threshold changes at a fixed level of 5
    repeat (6) @(negedge rclk);
    for (int n = 0; n < 5; n++) push_w(a, ad);
    check(afull == 0, "R8 afull below 12", int'(afull), 0);
    afull_lvl = 4;
    repeat (2) @(negedge wclk);
    check(afull == 1, "R8 afull after limit change", int'(afull), 1);
    repeat (6) @(negedge rclk);
    check(aempty == 0, "R9 aempty above 3", int'(aempty), 0);
    aempty_lvl = 6;
    repeat (2) @(negedge rclk);
    check(aempty == 1, "R9 aempty after limit change", int'(aempty), 1);

    summary();
  end
endmodule